// File: doc/BRIEF.md
# Power-Up Strap Latch and Mode Select

This block sits between a clock buffer's configuration pins and its PLL and output logic. It watches an asynchronous power-good input. On the first rising edge of that input after reset it captures two straps: a PLL operating-mode code and a frequency-select level. It then holds them until the next reset. A three-level mode pin is decoded elsewhere, so the strap arrives here as a 2-bit code. Every later rising edge of power-good is only an exit from power-down. It never refreshes the captured straps.

From the captured values and a software override taken from configuration registers, the block drives four things:
- the effective PLL mode;
- the frequency select;
- a PLL-on indication;
- a readback copy of the captured mode.

It also tells the output lane-gating logic which phase the device is in: the first power-good phase, or a power-down phase that follows it.

Top module: `ps_strap_ctl`

## Requirements
- R1: While reset is applied and afterwards until the first capture, `configured` is 0, `eff_mode` is 01 (bypass), `rb_mode` is 01, `freq_sel` is 1, `pll_on` is 0, and both phase outputs are 0.
- R2: The first low-to-high transition of `pwr_good` captures the straps, and `configured` rises SYNC_STAGES+1 clock edges after `pwr_good` goes high (3 edges by default).
- R3: Mode codes are 2'b00 low-bandwidth PLL, 2'b01 bypass, 2'b11 high-bandwidth PLL. A strap code of 2'b10 is captured as 2'b01.
- R4: `freq_sel` takes the captured frequency strap: 1 selects 100 MHz and 0 selects 133.33 MHz.
- R5: Rising edges of `pwr_good` after the first one leave the captured mode and frequency unchanged, and `configured` stays 1 until reset.
- R6: Once configured with `sw_en` = 1, `eff_mode` follows `sw_mode` in the same cycle, and `sw_mode` 2'b10 yields bypass (2'b01).
- R7: `rb_mode` always shows the captured strap code, whatever `sw_en` and `sw_mode` are. With `sw_en` = 0, `eff_mode` equals `rb_mode`.
- R8: `pll_on` is 0 when `eff_mode` is bypass and 1 in both bandwidth modes.
- R9: Before the first capture, `sw_en` and `sw_mode` have no effect on `eff_mode` or `pll_on`.
- R10: `in_first_up` is 1 from the capture until `pwr_good` is first seen low. `in_power_down` is 1 whenever the block is configured and the synchronized `pwr_good` is low, which happens SYNC_STAGES edges after the input falls. The two are never 1 together.
- R11: Changes of `strap_mode` or `strap_freq` after the capture have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good | input | 1 | Asynchronous power-good / power-down level |
| strap_mode | input | 2 | Decoded three-level mode strap (00 low, 01 mid, 11 high) |
| strap_freq | input | 1 | Frequency strap, 1 = 100 MHz, 0 = 133.33 MHz |
| sw_en | input | 1 | Software override enable from configuration register |
| sw_mode | input | 2 | Software mode code from configuration register |
| eff_mode | output | 2 | Effective PLL operating mode |
| freq_sel | output | 1 | Effective frequency select |
| rb_mode | output | 2 | Readback of the captured mode strap |
| pll_on | output | 1 | PLL is running (not bypass) |
| configured | output | 1 | Straps have been captured |
| in_first_up | output | 1 | In the first power-good phase |
| in_power_down | output | 1 | In a power-down phase after configuration |

## Verification
Each result has its own latency:
- After `pwr_good` rises, `configured` and the captured mode and frequency appear on the third clock edge.
- After `pwr_good` falls, `in_power_down` asserts on the second edge.
- Changes of `sw_en` and `sw_mode` reach `eff_mode` and `pll_on` without any clock edge.

The bench drives inputs on falling edges and counts falling edges to match those latencies. It checks one edge early where the exact arrival matters, for example that `configured` is still 0 after two edges. Checks that something is ignored wait several edges past the longest latency before they sample the outputs.

// File: rtl/ps_pkg.sv
package ps_pkg;

  typedef logic [1:0] mode_t;

  localparam mode_t MODE_LBW = 2'b00;
  localparam mode_t MODE_BYP = 2'b01;
  localparam mode_t MODE_RSV = 2'b10;
  localparam mode_t MODE_HBW = 2'b11;

  localparam logic FREQ_100 = 1'b1;

  // Fold the unused code onto bypass so that every consumer sees three values.
  function automatic mode_t fold_mode(input mode_t code);
    fold_mode = (code == MODE_RSV) ? MODE_BYP : code;
  endfunction

endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign chain_d[i] = d;
      end else begin : g_body
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/ps_strap_capture.sv
module ps_strap_capture
  import ps_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pg_s,
  input  mode_t strap_mode,
  input  logic  strap_freq,
  output logic  cfg,
  output mode_t lat_mode,
  output logic  lat_freq,
  output logic  first_up,
  output logic  power_down
);

  logic  pg_prev_q, pg_prev_d;
  logic  cfg_q, cfg_d;
  logic  down_q, down_d;
  mode_t mode_q, mode_d;
  logic  freq_q, freq_d;
  logic  cap_en;
  logic  down_en;

  // Capture only on the very first rising edge; afterwards the edge is ignored here.
  assign cap_en  = pg_s & ~pg_prev_q & ~cfg_q;
  assign down_en = cfg_q & ~pg_s;

  always_comb begin
    pg_prev_d = pg_s;
    cfg_d     = cfg_q;
    mode_d    = mode_q;
    freq_d    = freq_q;
    down_d    = down_q;
    if (cap_en) begin
      cfg_d  = 1'b1;
      mode_d = fold_mode(strap_mode);
      freq_d = strap_freq;
    end
    if (down_en) begin
      down_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_prev_q <= 1'b0;
      cfg_q     <= 1'b0;
      mode_q    <= MODE_BYP;
      freq_q    <= FREQ_100;
      down_q    <= 1'b0;
    end else begin
      pg_prev_q <= pg_prev_d;
      cfg_q     <= cfg_d;
      mode_q    <= mode_d;
      freq_q    <= freq_d;
      down_q    <= down_d;
    end
  end

  assign cfg        = cfg_q;
  assign lat_mode   = mode_q;
  assign lat_freq   = freq_q;
  assign first_up   = cfg_q & pg_s & ~down_q;
  assign power_down = cfg_q & ~pg_s;

endmodule

// File: rtl/ps_mode_sel.sv
module ps_mode_sel
  import ps_pkg::*;
(
  input  logic  cfg,
  input  mode_t lat_mode,
  input  logic  sw_en,
  input  mode_t sw_mode,
  output mode_t eff_mode,
  output logic  pll_on
);

  mode_t pick;

  always_comb begin
    if (!cfg) begin
      pick = MODE_BYP;
    end else if (sw_en) begin
      pick = fold_mode(sw_mode);
    end else begin
      pick = lat_mode;
    end
  end

  assign eff_mode = pick;
  assign pll_on   = (pick != MODE_BYP);

endmodule

// File: rtl/ps_strap_ctl.sv
module ps_strap_ctl
  import ps_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic [1:0] strap_mode,
  input  logic       strap_freq,
  input  logic       sw_en,
  input  logic [1:0] sw_mode,
  output logic [1:0] eff_mode,
  output logic       freq_sel,
  output logic [1:0] rb_mode,
  output logic       pll_on,
  output logic       configured,
  output logic       in_first_up,
  output logic       in_power_down
);

  logic  rst_n_int;
  logic  pg_s;
  logic  cfg;
  mode_t lat_mode;
  logic  lat_freq;

  ps_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_n_int)
  );

  ps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     (pwr_good),
    .q     (pg_s)
  );

  ps_strap_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .pg_s       (pg_s),
    .strap_mode (strap_mode),
    .strap_freq (strap_freq),
    .cfg        (cfg),
    .lat_mode   (lat_mode),
    .lat_freq   (lat_freq),
    .first_up   (in_first_up),
    .power_down (in_power_down)
  );

  ps_mode_sel u_sel (
    .cfg      (cfg),
    .lat_mode (lat_mode),
    .sw_en    (sw_en),
    .sw_mode  (sw_mode),
    .eff_mode (eff_mode),
    .pll_on   (pll_on)
  );

  assign configured = cfg;
  assign rb_mode    = lat_mode;
  assign freq_sel   = lat_freq;

endmodule

// File: rtl/ps_strap_ctl_chk.sv
module ps_strap_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_en,
  input logic [1:0] sw_mode,
  input logic [1:0] eff_mode,
  input logic       freq_sel,
  input logic [1:0] rb_mode,
  input logic       pll_on,
  input logic       configured,
  input logic       in_first_up,
  input logic       in_power_down
);

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    configured |=> configured); // R5

  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (configured && $past(configured)) |-> ($stable(rb_mode) && $stable(freq_sel))); // R11

  AST_PRECFG_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !configured |-> (eff_mode == 2'b01 && !pll_on && freq_sel)); // R9

  AST_SW_HBW: assert property (@(posedge clk) disable iff (!rst_n)
    (configured && sw_en && sw_mode == 2'b11) |-> (eff_mode == 2'b11)); // R6

  AST_HW_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (configured && !sw_en) |-> (eff_mode == rb_mode)); // R7

  AST_PLL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    configured |-> (pll_on != (eff_mode == 2'b01))); // R8

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_first_up && in_power_down)); // R10

  AST_PD_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    in_power_down |-> configured); // R10

endmodule

bind ps_strap_ctl ps_strap_ctl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sw_en         (sw_en),
  .sw_mode       (sw_mode),
  .eff_mode      (eff_mode),
  .freq_sel      (freq_sel),
  .rb_mode       (rb_mode),
  .pll_on        (pll_on),
  .configured    (configured),
  .in_first_up   (in_first_up),
  .in_power_down (in_power_down)
);

// File: tb/ps_strap_ctl_tb.sv
module ps_strap_ctl_tb;

  localparam int CAP_LAT = 3;
  localparam int PD_LAT  = 2;

  logic       clk;
  logic       rst_n;
  logic       pwr_good;
  logic [1:0] strap_mode;
  logic       strap_freq;
  logic       sw_en;
  logic [1:0] sw_mode;
  logic [1:0] eff_mode;
  logic       freq_sel;
  logic [1:0] rb_mode;
  logic       pll_on;
  logic       configured;
  logic       in_first_up;
  logic       in_power_down;

  int n_chk;
  int n_bad;
  bit finished;

  ps_strap_ctl u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_good      (pwr_good),
    .strap_mode    (strap_mode),
    .strap_freq    (strap_freq),
    .sw_en         (sw_en),
    .sw_mode       (sw_mode),
    .eff_mode      (eff_mode),
    .freq_sel      (freq_sel),
    .rb_mode       (rb_mode),
    .pll_on        (pll_on),
    .configured    (configured),
    .in_first_up   (in_first_up),
    .in_power_down (in_power_down)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    pwr_good = 1'b0;
    sw_en    = 1'b0;
    sw_mode  = 2'b00;
    negs(3);
    rst_n = 1'b1;
    negs(4);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1", "configured", configured, 0);
    check("R1", "eff_mode", eff_mode, 1);
    check("R1", "rb_mode", rb_mode, 1);
    check("R1", "freq_sel", freq_sel, 1);
    check("R1", "pll_on", pll_on, 0);
    check("R1", "in_first_up", in_first_up, 0);
    check("R1", "in_power_down", in_power_down, 0);
  endtask

  task automatic t_preconfig_override();
    sw_en   = 1'b1;
    sw_mode = 2'b11;
    negs(2);
    check("R9", "eff_mode", eff_mode, 1);
    check("R9", "pll_on", pll_on, 0);
    sw_en   = 1'b0;
    sw_mode = 2'b00;
    negs(1);
  endtask

  task automatic t_first_up(input logic [1:0] smode, input logic sfreq,
                            input int exp_mode, input int exp_pll);
    strap_mode = smode;
    strap_freq = sfreq;
    pwr_good   = 1'b1;
    negs(CAP_LAT - 1);
    check("R2", "configured early", configured, 0);
    negs(1);
    check("R2", "configured", configured, 1);
    check("R3", "rb_mode", rb_mode, exp_mode);
    check("R3", "eff_mode", eff_mode, exp_mode);
    check("R4", "freq_sel", freq_sel, sfreq);
    check("R8", "pll_on", pll_on, exp_pll);
    check("R10", "in_first_up", in_first_up, 1);
    check("R10", "in_power_down", in_power_down, 0);
  endtask

  task automatic t_strap_ignored();
    strap_mode = 2'b00;
    strap_freq = 1'b1;
    negs(5);
    check("R11", "eff_mode", eff_mode, 3);
    check("R11", "rb_mode", rb_mode, 3);
    check("R11", "freq_sel", freq_sel, 0);
  endtask

  task automatic t_sw_override();
    sw_en   = 1'b1;
    sw_mode = 2'b00;
    negs(1);
    check("R6", "eff_mode sw 00", eff_mode, 0);
    check("R7", "rb_mode under override", rb_mode, 3);
    check("R8", "pll_on lbw", pll_on, 1);
    sw_mode = 2'b01;
    negs(1);
    check("R6", "eff_mode sw 01", eff_mode, 1);
    check("R8", "pll_on bypass", pll_on, 0);
    sw_mode = 2'b10;
    negs(1);
    check("R6", "eff_mode sw 10", eff_mode, 1);
    check("R7", "rb_mode sw 10", rb_mode, 3);
    sw_en = 1'b0;
    negs(1);
    check("R7", "eff_mode back to strap", eff_mode, 3);
  endtask

  task automatic t_power_cycle();
    pwr_good = 1'b0;
    negs(PD_LAT - 1);
    check("R10", "in_power_down early", in_power_down, 0);
    negs(1);
    check("R10", "in_power_down", in_power_down, 1);
    check("R10", "in_first_up after drop", in_first_up, 0);
    check("R5", "configured in power down", configured, 1);
    strap_mode = 2'b01;
    strap_freq = 1'b1;
    pwr_good   = 1'b1;
    negs(5);
    check("R5", "eff_mode after exit", eff_mode, 3);
    check("R5", "freq_sel after exit", freq_sel, 0);
    check("R10", "in_power_down after exit", in_power_down, 0);
    check("R10", "in_first_up after exit", in_first_up, 0);
  endtask

  initial begin
    n_chk      = 0;
    n_bad      = 0;
    finished   = 1'b0;
    strap_mode = 2'b11;
    strap_freq = 1'b0;
    t_reset_state();
    t_preconfig_override();
    t_first_up(2'b11, 1'b0, 3, 1);
    t_strap_ignored();
    t_sw_override();
    t_power_cycle();
    t_reset_state();
    t_first_up(2'b00, 1'b1, 0, 1);
    t_reset_state();
    t_first_up(2'b01, 1'b0, 1, 0);
    t_reset_state();
    t_first_up(2'b10, 1'b1, 1, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule